// File: doc/BRIEF.md
# Three-Lane Complex SIMD Arithmetic Unit

This block is a pipelined arithmetic datapath that operates on a vector of three complex values per operation. The lane count matches one row or column of a 3x3 complex matrix, so a single issue advances one full vector step of matrix algebra. Each operation takes two vector operands `a` and `b`, a shared real scalar and a 3-bit operation code. It returns three complex results two clock cycles later, together with a valid flag.

The operations are lane-wise complex add and subtract, add and subtract of `b` rotated by the imaginary unit, scaling of `a` by the real scalar, and the full complex product. Every real and imaginary component is a 16-bit signed Q1.15 fixed-point value. Products are rounded to nearest, and every result saturates to the 16-bit range. The unit has no stalls and takes a new operation on every clock, so a compiler can schedule arithmetic every cycle alongside other work.

Top module: `cplx_simd3_unit`

## Requirements
- R1: The three lanes are computed independently. Lane k uses bits [16k+15:16k] of every vector port, and all lanes share the scalar and the opcode.
- R2: Opcode 0 gives a+b and opcode 1 gives a-b in each lane, applied to the real and imaginary parts separately, with saturation.
- R3: Opcode 2 gives a + i*b, that is re = a.re - b.im and im = a.im + b.re, with saturation.
- R4: Opcode 3 gives a - i*b, that is re = a.re + b.im and im = a.im - b.re, with saturation.
- R5: Opcode 4 multiplies both parts of each lane of `a` by the Q1.15 scalar `in_scale`.
- R6: Opcode 5 gives the complex product, re = a.re*b.re - a.im*b.im and im = a.re*b.im + a.im*b.re. Each part is formed at full precision before a single rounding step.
- R7: A full-precision product result P (scaled by 2^30) becomes floor((P + 2^14) / 2^15), so ties round upward. Every result of every opcode is clamped to [-32768, 32767].
- R8: `out_valid` is high exactly two clock edges after the edge that samples `in_valid` high, for every opcode. Operations issued on consecutive cycles all come out in order with no gaps.
- R9: Opcodes 6 and 7 give zero in every part of every lane, and `out_valid` still follows R8.
- R10: A synchronous active-high reset clears both pipeline valid stages. Operations in flight during the reset never raise `out_valid`, and operations presented while reset is high are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0..7) |
| in_a_re | input | 48 | Real parts of operand a, lane k at [16k+15:16k] |
| in_a_im | input | 48 | Imaginary parts of operand a |
| in_b_re | input | 48 | Real parts of operand b |
| in_b_im | input | 48 | Imaginary parts of operand b |
| in_scale | input | 16 | Real Q1.15 scalar for opcode 4 |
| out_valid | output | 1 | Result present this cycle |
| out_re | output | 48 | Real parts of result, lane layout as inputs |
| out_im | output | 48 | Imaginary parts of result |

## Verification
The hardest cases to reach from the ports are the extreme ends of the products. Examples are -1 times -1, which must clamp rather than wrap, a complex product whose imaginary part reaches 2^31, and exact half-LSB ties in rounding. Uniform random data almost never produces them. The stimulus therefore draws each component from a biased mix in which the two extreme codes come up often, and it adds directed operations for the tie cases. A reset is also applied while operations are still in the pipeline, to show that those in-flight results are dropped.

// File: rtl/cplx_simd_pkg.sv
`timescale 1ns/1ps
package cplx_simd_pkg;

    localparam int CW      = 16;          // component width
    localparam int FRAC    = CW - 1;      // fractional bits (Q1.15)
    localparam int PW      = 2 * CW + 2;  // internal wide width

    typedef logic signed [CW-1:0] comp_t;
    typedef logic signed [PW-1:0] wide_t;

    typedef struct packed {
        comp_t re;
        comp_t im;
    } cplx_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDI = 3'd2,
        OP_SUBI = 3'd3,
        OP_MULR = 3'd4,
        OP_MULC = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        K_ZERO = 2'd0,
        K_SUM  = 2'd1,
        K_PROD = 2'd2
    } kind_e;

    // Intermediate result held between the two stages
    typedef struct packed {
        kind_e kind;
        wide_t re;
        wide_t im;
    } mid_t;

    localparam wide_t SAT_HI   = wide_t'((64'sd1 <<< FRAC) - 64'sd1);
    localparam wide_t SAT_LO   = wide_t'(-(64'sd1 <<< FRAC));
    localparam wide_t RND_HALF = wide_t'(64'sd1 <<< (FRAC - 1));

    function automatic kind_e kind_of(input op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_ADDI, OP_SUBI: return K_SUM;
            OP_MULR, OP_MULC:                 return K_PROD;
            default:                          return K_ZERO;
        endcase
    endfunction

    function automatic comp_t clamp(input wide_t v);
        if (v > SAT_HI)      return comp_t'(SAT_HI);
        else if (v < SAT_LO) return comp_t'(SAT_LO);
        else                 return comp_t'(v);
    endfunction

    function automatic wide_t round_q(input wide_t v);
        return (v + RND_HALF) >>> FRAC;
    endfunction

    function automatic wide_t widen(input comp_t v);
        return wide_t'(v);
    endfunction

endpackage

// File: rtl/cplx_valid_pipe.sv
`timescale 1ns/1ps
module cplx_valid_pipe
    import cplx_simd_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= 1'b0;
                else if (s == 0) stage_q[s] <= vin;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign vout = stage_q[DEPTH-1];

endmodule

// File: rtl/cplx_lane_front.sv
`timescale 1ns/1ps
module cplx_lane_front
    import cplx_simd_pkg::*;
(
    input  logic  clk,
    input  cplx_t a,
    input  cplx_t b,
    input  comp_t scale,
    input  op_e   op,
    output mid_t  mid_q
);

    wide_t sum_re, sum_im;
    wide_t p0, p1, p2, p3;
    wide_t prod_re, prod_im;
    comp_t rhs_re;
    mid_t  mid_d;

    // Linear terms at full width (no overflow possible here)
    always_comb begin
        case (op)
            OP_SUB: begin
                sum_re = widen(a.re) - widen(b.re);
                sum_im = widen(a.im) - widen(b.im);
            end
            OP_ADDI: begin
                sum_re = widen(a.re) - widen(b.im);
                sum_im = widen(a.im) + widen(b.re);
            end
            OP_SUBI: begin
                sum_re = widen(a.re) + widen(b.im);
                sum_im = widen(a.im) - widen(b.re);
            end
            default: begin
                sum_re = widen(a.re) + widen(b.re);
                sum_im = widen(a.im) + widen(b.im);
            end
        endcase
    end

    // Four multipliers shared by the real-scale and complex products
    always_comb begin
        rhs_re  = (op == OP_MULR) ? scale : b.re;
        p0      = widen(a.re) * widen(rhs_re);
        p1      = widen(a.im) * widen(b.im);
        p2      = widen(a.re) * widen(b.im);
        p3      = widen(a.im) * widen(rhs_re);
        prod_re = p0 - ((op == OP_MULC) ? p1 : '0);
        prod_im = ((op == OP_MULC) ? p2 : '0) + p3;
    end

    always_comb begin
        mid_d.kind = kind_of(op);
        mid_d.re   = (mid_d.kind == K_PROD) ? prod_re : sum_re;
        mid_d.im   = (mid_d.kind == K_PROD) ? prod_im : sum_im;
    end

    always_ff @(posedge clk) begin
        mid_q <= mid_d;
    end

endmodule

// File: rtl/cplx_lane_back.sv
`timescale 1ns/1ps
module cplx_lane_back
    import cplx_simd_pkg::*;
(
    input  logic  clk,
    input  mid_t  mid,
    output cplx_t y_q
);

    cplx_t y_d;

    always_comb begin
        case (mid.kind)
            K_SUM: begin
                y_d.re = clamp(mid.re);
                y_d.im = clamp(mid.im);
            end
            K_PROD: begin
                y_d.re = clamp(round_q(mid.re));
                y_d.im = clamp(round_q(mid.im));
            end
            default: begin
                y_d.re = '0;
                y_d.im = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        y_q <= y_d;
    end

endmodule

// File: rtl/cplx_simd3_unit.sv
`timescale 1ns/1ps
module cplx_simd3_unit
    import cplx_simd_pkg::*;
#(
    parameter int LANES = 3,
    localparam int VW   = LANES * CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [VW-1:0] in_a_re,
    input  logic [VW-1:0] in_a_im,
    input  logic [VW-1:0] in_b_re,
    input  logic [VW-1:0] in_b_im,
    input  logic [CW-1:0] in_scale,
    output logic          out_valid,
    output logic [VW-1:0] out_re,
    output logic [VW-1:0] out_im
);

    op_e op;
    assign op = op_e'(in_op);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            cplx_t a, b, y;
            mid_t  mid;

            assign a.re = comp_t'(in_a_re[l*CW +: CW]);
            assign a.im = comp_t'(in_a_im[l*CW +: CW]);
            assign b.re = comp_t'(in_b_re[l*CW +: CW]);
            assign b.im = comp_t'(in_b_im[l*CW +: CW]);

            cplx_lane_front u_front (
                .clk   (clk),
                .a     (a),
                .b     (b),
                .scale (comp_t'(in_scale)),
                .op    (op),
                .mid_q (mid)
            );

            cplx_lane_back u_back (
                .clk (clk),
                .mid (mid),
                .y_q (y)
            );

            assign out_re[l*CW +: CW] = y.re;
            assign out_im[l*CW +: CW] = y.im;
        end
    endgenerate

    cplx_valid_pipe #(.DEPTH(2)) u_vpipe (
        .clk  (clk),
        .rst  (rst),
        .vin  (in_valid),
        .vout (out_valid)
    );

    // Port-level reference terms for lane 0, used by the checks below
    wide_t chk_add_re0;
    assign chk_add_re0 = widen(comp_t'(in_a_re[CW-1:0])) + widen(comp_t'(in_b_re[CW-1:0]));

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);                                        // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));                                  // R10
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b11) |-> ##2 (out_re == '0 && out_im == '0)); // R9
    AST_SCALE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4 && in_scale == '0) |-> ##2 (out_re == '0 && out_im == '0)); // R5
    AST_ADD_LANE0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0) |-> ##2 (comp_t'(out_re[CW-1:0]) == clamp($past(chk_add_re0, 2)))); // R2

endmodule

// File: tb/test_cplx_simd3_unit.sv
`timescale 1ns/1ps
module test_cplx_simd3_unit;

    localparam int CLK_P = 10;
    localparam int NL    = 3;
    localparam int W     = 16;
    localparam int VW    = NL * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [VW-1:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
    logic [W-1:0]  in_scale = '0;
    logic          out_valid;
    logic [VW-1:0] out_re, out_im;

    cplx_simd3_unit i_cplx_simd3_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
        .in_scale(in_scale), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic          v;
        logic [2:0]    op;
        logic [VW-1:0] ar, ai, br, bi;
        logic [W-1:0]  s;
    } entry_t;

    entry_t hist0 = '0, hist1 = '0, cur = '0;
    logic   nrst = 1'b1;
    int     n_chk = 0, n_fail = 0;
    bit     done = 1'b0;

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint sat(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rnd(input longint p);
        return (p + 16384) >>> 15;
    endfunction

    // Reference per lane: returns {re, im}
    function automatic logic [2*W-1:0] ref_lane(input logic [2:0] op,
            input logic [W-1:0] ar, ai, br, bi, s);
        longint re, im;
        case (op)
            3'd0: begin re = sx(ar) + sx(br); im = sx(ai) + sx(bi); end
            3'd1: begin re = sx(ar) - sx(br); im = sx(ai) - sx(bi); end
            3'd2: begin re = sx(ar) - sx(bi); im = sx(ai) + sx(br); end
            3'd3: begin re = sx(ar) + sx(bi); im = sx(ai) - sx(br); end
            3'd4: begin re = rnd(sx(ar) * sx(s)); im = rnd(sx(ai) * sx(s)); end
            3'd5: begin
                re = rnd(sx(ar) * sx(br) - sx(ai) * sx(bi));
                im = rnd(sx(ar) * sx(bi) + sx(ai) * sx(br));
            end
            default: begin re = 0; im = 0; end
        endcase
        return {W'(sat(re)), W'(sat(im))};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3:       return "R4";
            3'd4:       return "R5/R7";
            3'd5:       return "R6/R7";
            default:    return "R9";
        endcase
    endfunction

    task automatic check_out();
        n_chk++;
        if (out_valid !== hist1.v) begin
            n_fail++;
            $display("FAIL R8/R10 out_valid actual=%b expected=%b", out_valid, hist1.v);
        end
        if (hist1.v) begin
            for (int l = 0; l < NL; l++) begin
                logic [2*W-1:0] e;
                e = ref_lane(hist1.op, hist1.ar[l*W +: W], hist1.ai[l*W +: W],
                             hist1.br[l*W +: W], hist1.bi[l*W +: W], hist1.s);
                n_chk++;
                if (out_re[l*W +: W] !== e[2*W-1:W] || out_im[l*W +: W] !== e[W-1:0]) begin
                    n_fail++;
                    $display("FAIL %s (R1 lane %0d op %0d) actual=%h/%h expected=%h/%h",
                             req_of(hist1.op), l, hist1.op, out_re[l*W +: W],
                             out_im[l*W +: W], e[2*W-1:W], e[W-1:0]);
                end
            end
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        check_out();
        hist1    = hist0;
        rst      = nrst;
        in_valid = cur.v;
        in_op    = cur.op;
        in_a_re  = cur.ar;
        in_a_im  = cur.ai;
        in_b_re  = cur.br;
        in_b_im  = cur.bi;
        in_scale = cur.s;
        hist0    = cur;
        if (nrst) begin
            hist0.v = 1'b0;
            hist1.v = 1'b0;
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] op,
            input logic [W-1:0] ar, ai, br, bi, s);
        cur.v  = v;
        cur.op = op;
        cur.ar = {NL{ar}};
        cur.ai = {NL{ai}};
        cur.br = {NL{br}};
        cur.bi = {NL{bi}};
        cur.s  = s;
        cycle();
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 7))
            0:       return 16'h8000;
            1:       return 16'h7FFF;
            2:       return 16'h0001;
            default: return W'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20110517));
        // R10: reset with valid operations presented
        nrst = 1'b1;
        for (int i = 0; i < 4; i++) issue(1'b1, 3'd0, 16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0);
        nrst = 1'b0;
        issue(1'b0, 3'd0, '0, '0, '0, '0, '0);

        // R8: back-to-back, every opcode, all valid
        for (int k = 0; k < 8; k++)
            issue(1'b1, 3'(k), 16'h1234, 16'hF00D, 16'h0ACE, 16'hC0DE, 16'h4000);

        // Saturation corners (R2, R3, R4)
        issue(1'b1, 3'd0, 16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF, '0);
        issue(1'b1, 3'd1, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, '0);
        issue(1'b1, 3'd2, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000, '0);
        issue(1'b1, 3'd3, 16'h8000, 16'h8000, 16'h7FFF, 16'h8000, '0);
        // R5/R7: -1 * -1 clamps; half-LSB ties round upward
        issue(1'b1, 3'd4, 16'h8000, 16'h8000, '0, '0, 16'h8000);
        issue(1'b1, 3'd4, 16'h0001, 16'hFFFF, '0, '0, 16'h4000);
        issue(1'b1, 3'd4, 16'h0003, 16'hFFFD, '0, '0, 16'h4000);
        // R6/R7: complex product with imaginary part at 2^31
        issue(1'b1, 3'd5, 16'h8000, 16'h8000, 16'h8000, 16'h8000, '0);
        issue(1'b1, 3'd5, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF, '0);
        // R9: reserved codes with nonzero data
        issue(1'b1, 3'd6, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
        issue(1'b1, 3'd7, 16'h8000, 16'h1111, 16'h2222, 16'h3333, 16'h4444);

        // R10: reset while operations are in flight
        issue(1'b1, 3'd0, 16'h0001, 16'h0002, 16'h0003, 16'h0004, '0);
        issue(1'b1, 3'd1, 16'h0005, 16'h0006, 16'h0007, 16'h0008, '0);
        nrst = 1'b1;
        issue(1'b1, 3'd5, 16'h1000, 16'h1000, 16'h1000, 16'h1000, '0);
        nrst = 1'b0;
        issue(1'b0, 3'd0, '0, '0, '0, '0, '0);
        issue(1'b0, 3'd0, '0, '0, '0, '0, '0);

        // Random mix, distinct data in each lane (R1)
        for (int n = 0; n < 4000; n++) begin
            cur.v  = ($urandom_range(0, 4) != 0);
            cur.op = 3'($urandom_range(0, 7));
            for (int l = 0; l < NL; l++) begin
                cur.ar[l*W +: W] = pick();
                cur.ai[l*W +: W] = pick();
                cur.br[l*W +: W] = pick();
                cur.bi[l*W +: W] = pick();
            end
            cur.s = pick();
            cycle();
        end

        // Drain
        cur = '0;
        for (int i = 0; i < 3; i++) cycle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule